// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It does this by reading a two-level page hierarchy from memory, with pages of 4 KB. A client raises a request that carries the linear address, a write flag, the directory base word and the paging-enable control. The walker takes the request only when it is idle and latches all of these inputs. It then fetches one directory word and one table word through a single-outstanding memory read port. It returns either the translated address or a fault together with a cause code. The result is presented for exactly one cycle.

The linear address is cut into three fields: a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit byte offset. Each entry is 4 bytes wide. The upper 20 bits of an entry give the 4 KB-aligned base of the next level. The low 12 bits hold flags: bit 0 means present and bit 1 means writable. When paging is disabled, the walker hands the linear address straight back and does not touch memory.

Top module: `pgw_walker`

## Requirements
- R1: The first read of a paged walk goes to address {base[31:12], la[31:22], 2'b00}.
- R2: The second read goes to address {dir_entry[31:12], la[21:12], 2'b00}.
- R3: A successful walk returns rsp_fault=0, rsp_cause=0 and rsp_pa={tbl_entry[31:12], la[11:0]}.
- R4: With paging_en=0 at acceptance, the response comes one cycle after acceptance with rsp_pa equal to the linear address, no fault and no memory read.
- R5: A directory entry whose bit 0 is clear gives a fault with rsp_cause=1 after exactly one read. On every fault, rsp_pa carries the linear address.
- R6: A table entry whose bit 0 is clear gives a fault with rsp_cause=2.
- R7: A write whose directory entry or table entry has bit 1 clear gives a fault with rsp_cause=3. A directory-level write fault stops after one read. A read access ignores bit 1.
- R8: While mem_req is high and no mem_rvalid has arrived, mem_req stays high and mem_addr stays unchanged.
- R9: req_ready is high only in the idle state, so a request that arrives while a walk is in progress is not taken. rsp_valid is high for exactly one cycle per accepted request.
- R10: While rst_n is low, the walker goes to idle: req_ready=1, mem_req=0, rsp_valid=0.
- R11: With base 0x1000, a directory word 0x2003 at 0x1000, table words (i<<12)|3 at 0x2000+4i for i=0..5 and 0x6003 at 0x2030, linear 0xC000 maps to 0x6000 and 0x0000..0x5FFF maps onto itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High when a request can be taken (idle) |
| req_la | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| dir_base | input | 32 | Directory base word; bits 31:12 are used |
| paging_en | input | 1 | Translation enable; when 0 the address passes through |
| mem_req | output | 1 | Memory read strobe, held until mem_rvalid |
| mem_addr | output | 32 | Word address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (entry word) |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Result is a fault |
| rsp_cause | output | 2 | 0 none, 1 directory absent, 2 table absent, 3 write to read-only |
| rsp_pa | output | 32 | Physical address, or the linear address on a fault |

## Verification
The bench builds the walker with its default split: a 32-bit address, 10-bit indices and a 12-bit offset. This is the only split in which the directed layout with a directory at 0x1000 and a table at 0x2000 is meaningful. With those values, every present/writable flag pattern at both levels can be reached, and so can every fault cause and the paging bypass. The memory model answers after a random delay of zero to three cycles. This exercises the hold of the read address and strobe during both the single-read and the double-read walks.

// File: rtl/pgw_pkg.sv
// Package: shared types for the page table walker.
// Assumes: two-bit cause encoding that the client decodes as listed.
package pgw_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'd0,
        CAUSE_DIR_ABSENT = 2'd1,
        CAUSE_TBL_ABSENT = 2'd2,
        CAUSE_WR_PROT    = 2'd3
    } pgw_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FETCH_DIR = 2'd1,
        ST_FETCH_TBL = 2'd2,
        ST_RESP      = 2'd3
    } pgw_state_e;

endpackage

// File: rtl/pgw_entry_addr.sv
// Module: forms the byte address of one entry from a level base and an index.
// Assumes: base is aligned to 2**OFFS_W bytes and IDX_W + ENTRY_SH == OFFS_W.
module pgw_entry_addr #(
    parameter int ADDR_W   = 32,
    parameter int OFFS_W   = 12,
    parameter int IDX_W    = 10,
    parameter int ENTRY_SH = 2
) (
    input  logic [ADDR_W-OFFS_W-1:0] base_frame,
    input  logic [IDX_W-1:0]         index,
    output logic [ADDR_W-1:0]        entry_addr
);

    // Concatenate the frame, the scaled index and zero byte-select bits.
    always_comb begin
        entry_addr = {base_frame, index, {ENTRY_SH{1'b0}}};
    end

endmodule

// File: rtl/pgw_entry_check.sv
// Module: judges one fetched entry for presence and write permission.
// Assumes: bit 0 is the present flag, bit 1 the writable flag; LEAF selects
// which absence cause is reported (directory or table level).
module pgw_entry_check
    import pgw_pkg::*;
#(
    parameter bit LEAF = 1'b0
) (
    input  logic       present,
    input  logic       writable,
    input  logic       is_write,
    output logic       fault,
    output pgw_cause_e cause
);

    localparam pgw_cause_e ABSENT_CAUSE = LEAF ? CAUSE_TBL_ABSENT : CAUSE_DIR_ABSENT;

    // Presence takes priority over permission; reads never check bit 1.
    always_comb begin
        fault = 1'b0;
        cause = CAUSE_NONE;
        if (!present) begin
            fault = 1'b1;
            cause = ABSENT_CAUSE;
        end else if (is_write && !writable) begin
            fault = 1'b1;
            cause = CAUSE_WR_PROT;
        end
    end

endmodule

// File: rtl/pgw_walker.sv
// Module: two-level page table walker, top level.
// Assumes: a memory port with one read outstanding; the responder answers
// with mem_rvalid while mem_req is high. The address split is
// ADDR_W = 2*IDX_W + OFFS_W and each entry is ENTRY_BYTES wide.
module pgw_walker
    import pgw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int OFFS_W      = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_la,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              paging_en,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [ADDR_W-1:0] rsp_pa
);

    localparam int ENTRY_SH = $clog2(ENTRY_BYTES);
    localparam int FRAME_W  = ADDR_W - OFFS_W;
    localparam int DIR_LSB  = OFFS_W + IDX_W;

    pgw_state_e          state_q;
    logic [ADDR_W-1:0]   la_q;
    logic                wr_q;
    logic [FRAME_W-1:0]  base_frame_q;
    logic [FRAME_W-1:0]  tbl_frame_q;
    logic [ADDR_W-1:0]   dir_addr;
    logic [ADDR_W-1:0]   tbl_addr;
    logic                dir_fault;
    pgw_cause_e          dir_cause;
    logic                tbl_fault;
    pgw_cause_e          tbl_cause;
    logic                fault_q;
    pgw_cause_e          cause_q;
    logic [ADDR_W-1:0]   pa_q;

    pgw_entry_addr #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W), .ENTRY_SH(ENTRY_SH)
    ) u_dir_addr (
        .base_frame (base_frame_q),
        .index      (la_q[ADDR_W-1:DIR_LSB]),
        .entry_addr (dir_addr)
    );

    pgw_entry_addr #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W), .ENTRY_SH(ENTRY_SH)
    ) u_tbl_addr (
        .base_frame (tbl_frame_q),
        .index      (la_q[DIR_LSB-1:OFFS_W]),
        .entry_addr (tbl_addr)
    );

    pgw_entry_check #(.LEAF(1'b0)) u_dir_chk (
        .present  (mem_rdata[0]),
        .writable (mem_rdata[1]),
        .is_write (wr_q),
        .fault    (dir_fault),
        .cause    (dir_cause)
    );

    // The directory write bit was already checked, so only the leaf bit matters here.
    pgw_entry_check #(.LEAF(1'b1)) u_tbl_chk (
        .present  (mem_rdata[0]),
        .writable (mem_rdata[1]),
        .is_write (wr_q),
        .fault    (tbl_fault),
        .cause    (tbl_cause)
    );

    // Walk sequencing: accept, fetch directory entry, fetch table entry, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            la_q         <= '0;
            wr_q         <= 1'b0;
            base_frame_q <= '0;
            tbl_frame_q  <= '0;
            fault_q      <= 1'b0;
            cause_q      <= CAUSE_NONE;
            pa_q         <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        la_q         <= req_la;
                        wr_q         <= req_write;
                        base_frame_q <= dir_base[ADDR_W-1:OFFS_W];
                        if (paging_en) begin
                            state_q <= ST_FETCH_DIR;
                        end else begin
                            pa_q    <= req_la;
                            fault_q <= 1'b0;
                            cause_q <= CAUSE_NONE;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_FETCH_DIR: begin
                    if (mem_rvalid) begin
                        if (dir_fault) begin
                            pa_q    <= la_q;
                            fault_q <= 1'b1;
                            cause_q <= dir_cause;
                            state_q <= ST_RESP;
                        end else begin
                            tbl_frame_q <= mem_rdata[ADDR_W-1:OFFS_W];
                            state_q     <= ST_FETCH_TBL;
                        end
                    end
                end
                ST_FETCH_TBL: begin
                    if (mem_rvalid) begin
                        fault_q <= tbl_fault;
                        cause_q <= tbl_cause;
                        pa_q    <= tbl_fault ? la_q
                                             : {mem_rdata[ADDR_W-1:OFFS_W], la_q[OFFS_W-1:0]};
                        state_q <= ST_RESP;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Port drive: the read address follows the level being fetched.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_FETCH_DIR) || (state_q == ST_FETCH_TBL);
        mem_addr  = (state_q == ST_FETCH_TBL) ? tbl_addr : dir_addr;
        rsp_valid = (state_q == ST_RESP);
        rsp_fault = fault_q;
        rsp_cause = cause_q;
        rsp_pa    = pa_q;
    end

endmodule

// File: rtl/pgw_walker_chk.sv
// Module: property checker for the page table walker, bound to the top.
// Assumes: default 32-bit address width.
module pgw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_la,
    input logic        paging_en,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [1:0]  rsp_cause,
    input logic [31:0] rsp_pa
);

    logic [1:0] rd_cnt;

    // Count reads completed since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 2'd0;
        end else if (req_valid && req_ready) begin
            rd_cnt <= 2'd0;
        end else if (mem_req && mem_rvalid) begin
            rd_cnt <= rd_cnt + 2'd1;
        end
    end

    a_r8_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=>
            (rsp_valid && !rsp_fault && !mem_req && rsp_pa == $past(req_la)));

    a_r5_dir_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && rsp_cause == 2'd1) |-> (rd_cnt == 2'd1));

    a_r6_tbl_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && rsp_cause == 2'd2) |-> (rd_cnt == 2'd2));

    a_r3_ok_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !mem_req));

endmodule

bind pgw_walker pgw_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_la     (req_la),
    .paging_en  (paging_en),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_cause  (rsp_cause),
    .rsp_pa     (rsp_pa)
);

// File: tb/pgw_walker_test.sv
`timescale 1ns/1ps
// Bench: directed layout plus hashed random tables, checked against a reference walk.
module pgw_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_la = '0;
    logic        req_write = 1'b0;
    logic [31:0] dir_base = '0;
    logic        paging_en = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_pa;

    int checks = 0;
    int errors = 0;
    int rd_n = 0;
    int wait_cnt = 0;
    int addr_moves = 0;
    logic [31:0] rd_addr [0:3];
    logic [31:0] held_addr = '0;
    logic        holding = 1'b0;

    always #2.5 clk = ~clk;

    pgw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_la(req_la), .req_write(req_write), .dir_base(dir_base),
        .paging_en(paging_en), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_pa(rsp_pa)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Memory contents: a small hand-built layout plus hashed words elsewhere.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] h;
        if (a >= 32'h1000 && a < 32'h4000) begin
            case (a)
                32'h1000: return 32'h2003;
                32'h1004: return 32'h3002;
                32'h1008: return 32'h3001;
                32'h2030: return 32'h6003;
                32'h2034: return 32'h7003;
                32'h2038: return 32'h8003;
                32'h203C: return 32'h9003;
                32'h2044: return 32'h9001;
                32'h3000: return 32'h8003;
                default: begin
                    if (a >= 32'h2000 && a <= 32'h2014)
                        return ((a - 32'h2000) << 10) | 32'h3;
                    return 32'h0;
                end
            endcase
        end
        h = (a ^ 32'h5A17C3E1) * 32'h9E3779B1;
        h = h ^ (h >> 15);
        return {h[31:12], 10'd0, (h[5:4] != 2'd0), (h[3:0] != 4'd0)};
    endfunction

    // Reference walk computed from the requirements.
    function automatic void ref_walk(input logic [31:0] la, input logic wr,
        input logic [31:0] base, input logic en, output logic [31:0] pa,
        output logic flt, output logic [1:0] cause, output int nrd,
        output logic [31:0] a0, output logic [31:0] a1);
        logic [31:0] pde;
        logic [31:0] pte;
        pa = la; flt = 1'b0; cause = 2'd0; nrd = 0; a0 = '0; a1 = '0;
        if (!en) return;
        a0 = {base[31:12], la[31:22], 2'b00};
        pde = mem_word(a0); nrd = 1;
        if (!pde[0]) begin flt = 1'b1; cause = 2'd1; return; end
        if (wr && !pde[1]) begin flt = 1'b1; cause = 2'd3; return; end
        a1 = {pde[31:12], la[21:12], 2'b00};
        pte = mem_word(a1); nrd = 2;
        if (!pte[0]) begin flt = 1'b1; cause = 2'd2; end
        else if (wr && !pte[1]) begin flt = 1'b1; cause = 2'd3; end
        else pa = {pte[31:12], la[11:0]};
    endfunction

    // Memory responder: random 0..3 cycle delay, records addresses, watches the hold.
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                if (holding && mem_addr != held_addr) addr_moves++;
                holding = 1'b1;
                held_addr = mem_addr;
                if (wait_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = mem_word(mem_addr);
                    if (rd_n < 4) rd_addr[rd_n] = mem_addr;
                    rd_n++;
                    holding = 1'b0;
                    wait_cnt = $urandom_range(0, 3);
                end else begin
                    wait_cnt--;
                end
            end else begin
                holding = 1'b0;
            end
        end
    end

    task automatic xlate(input logic [31:0] la, input logic wr, input logic [31:0] base,
                         input logic en, input string tag);
        logic [31:0] epa, a0, a1;
        logic eflt;
        logic [1:0] ecause;
        int enrd;
        int lat;
        ref_walk(la, wr, base, en, epa, eflt, ecause, enrd, a0, a1);
        @(negedge clk);
        rd_n = 0;
        req_valid = 1'b1; req_la = la; req_write = wr; dir_base = base; paging_en = en;
        @(negedge clk);
        req_valid = 1'b0; req_la = ~la;
        lat = 1;
        if (en) check(req_ready == 1'b0, {"R9 busy ", tag}, {31'd0, req_ready}, 32'd0);
        while (!rsp_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        check(rsp_valid, {"R9 response seen ", tag}, {31'd0, rsp_valid}, 32'd1);
        check(rsp_pa == epa, {tag, " pa"}, rsp_pa, epa);
        check(rsp_fault == eflt && rsp_cause == ecause, {tag, " fault/cause"},
              {29'd0, rsp_fault, rsp_cause}, {29'd0, eflt, ecause});
        check(rd_n == enrd, {tag, " read count"}, rd_n, enrd);
        if (enrd >= 1) check(rd_addr[0] == a0, {"R1 dir addr ", tag}, rd_addr[0], a0);
        if (enrd >= 2) check(rd_addr[1] == a1, {"R2 tbl addr ", tag}, rd_addr[1], a1);
        if (!en) check(lat == 1, {"R4 latency ", tag}, lat, 1);
        @(negedge clk);
        check(!rsp_valid, {"R9 one-cycle pulse ", tag}, {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(req_ready && !mem_req && !rsp_valid, "R10 reset state",
              {29'd0, req_ready, mem_req, rsp_valid}, 32'h4);
        rst_n = 1'b1;
        // R11 / R3: directed mapping
        xlate(32'h0000C000, 1'b0, 32'h1000, 1'b1, "R11 0xC000");
        xlate(32'h0000C123, 1'b1, 32'h1000, 1'b1, "R3 0xC123 write");
        for (int i = 0; i < 6; i++)
            xlate(32'(i) * 32'h1000 + 32'hABC, 1'b0, 32'h1000, 1'b1, "R11 identity");
        xlate(32'h0000FFFF, 1'b1, 32'h1000, 1'b1, "R3 last mapped page");
        // R6, R7, R5
        xlate(32'h00010000, 1'b0, 32'h1000, 1'b1, "R6 table absent");
        xlate(32'h00011010, 1'b1, 32'h1000, 1'b1, "R7 leaf read-only write");
        xlate(32'h00011010, 1'b0, 32'h1000, 1'b1, "R7 leaf read-only read");
        xlate(32'h00400000, 1'b0, 32'h1000, 1'b1, "R5 dir absent");
        xlate(32'h00800004, 1'b1, 32'h1000, 1'b1, "R7 dir read-only write");
        xlate(32'h00800004, 1'b0, 32'h1000, 1'b1, "R7 dir read-only read");
        // R4: bypass
        xlate(32'hDEADBEEF, 1'b1, 32'h1000, 1'b0, "R4 bypass");
        xlate(32'h0000C000, 1'b0, 32'h1000, 1'b0, "R4 bypass mapped addr");
        // Random walks over hashed tables
        for (int n = 0; n < 300; n++) begin
            xlate($urandom, 1'($urandom_range(0, 1)), {$urandom_range(16, 1000), 12'h0},
                  ($urandom_range(0, 7) != 0), "R3 random walk");
        end
        check(addr_moves == 0, "R8 read held until data", addr_moves, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule